// File: doc/BRIEF.md
# Exception Return Frame Unstacker

This block carries out the return half of exception handling. It is given the current stack pointer and the address of the return instruction, and it is started with a one-cycle request. It reads the first longword of the saved frame through a single 32-bit read port. It checks the frame's 4-bit format code before it changes any register. It reloads the status register from the low half of that word. It then fetches the saved return address from the next longword. Last, it produces the new stack pointer and the new program counter.

A frame whose format code is not on the accepted list is refused after the first read. An older layout, recognised by bit 30 of the first word being clear, is refused in the same way. On a refusal the block pulses a format-error flag and reports the return instruction's own address as the program counter. The status register and the stack pointer keep their values, and no second read is made. Building the error frame is left to the surrounding core.

Top module: `exc_frame_pop`

## Requirements
- R1: A synchronous reset returns the sequencer to idle. It clears `statusOut`, `pcOut`, `spOut`, `donePulse` and `fmtErrPulse`, and drops `memReq` and `busy`, including when a sequence is in progress.
- R2: On an accepted start, the first read addresses `stackPtr` as sampled with the start. `memReq` and `memAddr` hold steady until a cycle in which `memValid` is high completes the read.
- R3: The format code is bits [31:28] of the first word. Only the codes 4, 5, 6 and 7 are accepted; every other code (for example 12 or 15) is a format error.
- R4: A first word with bit 30 clear (codes 0 to 3 and 8 to 11, the older layout) is always a format error.
- R5: On a format error, exactly one read is made. `fmtErrPulse` is high for one cycle, in the cycle after the read completes. `pcOut` shows the sampled `instrAddr`, and `statusOut` and `spOut` are left unchanged.
- R6: For an accepted frame, `statusOut` takes bits [15:0] of the first word in the cycle after the first read completes, while the second read is still pending.
- R7: The second read addresses the sampled `stackPtr` plus 4.
- R8: When the second read completes, `pcOut` takes the second word. `spOut` becomes the sampled `stackPtr` + 4 + the format code, wrapping modulo 2^32. `donePulse` is high for exactly one cycle.
- R9: `donePulse` and `fmtErrPulse` are never high together.
- R10: A start request while `busy` is high is ignored. The read address and the final results of the running sequence are unaffected, and no extra sequence follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| startReq | input | 1 | Start pulse, sampled only while idle |
| stackPtr | input | 32 | Stack pointer at the frame, sampled with the start |
| instrAddr | input | 32 | Address of the return instruction, sampled with the start |
| memReq | output | 1 | Read request, held until served |
| memAddr | output | 32 | Read byte address |
| memValid | input | 1 | Read data valid; completes the pending read |
| memData | input | 32 | Read data |
| statusOut | output | 16 | Restored status register |
| pcOut | output | 32 | New program counter, or the faulting instruction address |
| spOut | output | 32 | Updated stack pointer |
| donePulse | output | 1 | One-cycle pulse: frame unstacked |
| fmtErrPulse | output | 1 | One-cycle pulse: frame refused |
| busy | output | 1 | Sequence in progress |

## Verification
A wrong sequencer state would show at the ports within one cycle of the next read completing. The symptoms would be a second read after a refused frame, a missing second read, a request with the wrong address, or both flags high at once. A wrong captured base or format code would show only at the end of a sequence, as a stack pointer off by the format value or by the word size. The bench therefore samples `spOut`, `pcOut` and `statusOut` in the cycle after each read completes. It also counts reads per sequence, so both kinds of fault are caught in the same sequence.

// File: rtl/exc_frame_pop_pkg.sv
package exc_frame_pop_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HEAD = 2'd1,
    ST_ADDR = 2'd2
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic captureBase;   // sample stack pointer and instruction address
    logic loadStatus;    // restore status word and keep format code
    logic loadFaultPc;   // report faulting instruction address
    logic loadPc;        // take return address
    logic loadSp;        // write adjusted stack pointer
    logic selSecond;     // address the second longword
  } dpCtrl_t;

endpackage

// File: rtl/exc_frame_pop_dp.sv
module exc_frame_pop_dp
  import exc_frame_pop_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int SR_W       = 16,
  parameter int FMT_W      = 4,
  parameter int FMT_LSB    = 28,
  parameter int LAYOUT_BIT = 30,
  parameter int WORD_BYTES = 4,
  parameter int FMT_LO     = 4,
  parameter int FMT_HI     = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  dpCtrl_t           ctrl,
  input  logic [ADDR_W-1:0] stackPtr,
  input  logic [ADDR_W-1:0] instrAddr,
  input  logic [DATA_W-1:0] memData,
  output logic [ADDR_W-1:0] memAddr,
  output logic              frameOk,
  output logic [SR_W-1:0]   statusOut,
  output logic [ADDR_W-1:0] pcOut,
  output logic [ADDR_W-1:0] spOut
);

  localparam int NUM_FMT = 1 << FMT_W;
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

  logic [ADDR_W-1:0] baseSp;
  logic [ADDR_W-1:0] faultPc;
  logic [FMT_W-1:0]  fmtReg;
  logic [FMT_W-1:0]  fmtField;
  logic [NUM_FMT-1:0] codeAllowed;
  logic [ADDR_W-1:0] nextWordAddr;

  // whitelist of accepted format codes
  for (genvar c = 0; c < NUM_FMT; c++) begin : g_allow
    assign codeAllowed[c] = (c >= FMT_LO) && (c <= FMT_HI);
  end

  assign fmtField     = memData[FMT_LSB +: FMT_W];
  assign frameOk      = codeAllowed[fmtField] && memData[LAYOUT_BIT];
  assign nextWordAddr = baseSp + STEP;
  assign memAddr      = ctrl.selSecond ? nextWordAddr : baseSp;

  always_ff @(posedge clk) begin
    if (rst) begin
      baseSp  <= '0;
      faultPc <= '0;
    end else if (ctrl.captureBase) begin
      baseSp  <= stackPtr;
      faultPc <= instrAddr;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      statusOut <= '0;
      fmtReg    <= '0;
    end else if (ctrl.loadStatus) begin
      statusOut <= memData[SR_W-1:0];
      fmtReg    <= fmtField;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pcOut <= '0;
    end else if (ctrl.loadPc) begin
      pcOut <= memData[ADDR_W-1:0];
    end else if (ctrl.loadFaultPc) begin
      pcOut <= faultPc;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      spOut <= '0;
    end else if (ctrl.loadSp) begin
      spOut <= nextWordAddr + {{(ADDR_W-FMT_W){1'b0}}, fmtReg};
    end
  end

endmodule

// File: rtl/exc_frame_pop_ctrl.sv
module exc_frame_pop_ctrl
  import exc_frame_pop_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    startReq,
  input  logic    memValid,
  input  logic    frameOk,
  output dpCtrl_t ctrl,
  output logic    memReq,
  output logic    busy,
  output logic    donePulse,
  output logic    fmtErrPulse
);

  seqState_t state;
  seqState_t stateNext;

  always_comb begin
    ctrl      = '0;
    stateNext = state;
    unique case (state)
      ST_IDLE: begin
        if (startReq) begin
          ctrl.captureBase = 1'b1;
          stateNext        = ST_HEAD;
        end
      end
      ST_HEAD: begin
        if (memValid) begin
          if (frameOk) begin
            ctrl.loadStatus = 1'b1;
            stateNext       = ST_ADDR;
          end else begin
            ctrl.loadFaultPc = 1'b1;
            stateNext        = ST_IDLE;
          end
        end
      end
      ST_ADDR: begin
        ctrl.selSecond = 1'b1;
        if (memValid) begin
          ctrl.loadPc = 1'b1;
          ctrl.loadSp = 1'b1;
          stateNext   = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      donePulse   <= 1'b0;
      fmtErrPulse <= 1'b0;
    end else begin
      state       <= stateNext;
      donePulse   <= ctrl.loadPc;
      fmtErrPulse <= ctrl.loadFaultPc;
    end
  end

  assign memReq = (state == ST_HEAD) || (state == ST_ADDR);
  assign busy   = (state != ST_IDLE);

endmodule

// File: rtl/exc_frame_pop.sv
module exc_frame_pop
  import exc_frame_pop_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int SR_W       = 16,
  parameter int FMT_W      = 4,
  parameter int FMT_LSB    = 28,
  parameter int LAYOUT_BIT = 30,
  parameter int WORD_BYTES = 4,
  parameter int FMT_LO     = 4,
  parameter int FMT_HI     = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              startReq,
  input  logic [ADDR_W-1:0] stackPtr,
  input  logic [ADDR_W-1:0] instrAddr,
  output logic              memReq,
  output logic [ADDR_W-1:0] memAddr,
  input  logic              memValid,
  input  logic [DATA_W-1:0] memData,
  output logic [SR_W-1:0]   statusOut,
  output logic [ADDR_W-1:0] pcOut,
  output logic [ADDR_W-1:0] spOut,
  output logic              donePulse,
  output logic              fmtErrPulse,
  output logic              busy
);

  dpCtrl_t ctrl;
  logic    frameOk;

  exc_frame_pop_ctrl u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .startReq    (startReq),
    .memValid    (memValid),
    .frameOk     (frameOk),
    .ctrl        (ctrl),
    .memReq      (memReq),
    .busy        (busy),
    .donePulse   (donePulse),
    .fmtErrPulse (fmtErrPulse)
  );

  exc_frame_pop_dp #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .SR_W       (SR_W),
    .FMT_W      (FMT_W),
    .FMT_LSB    (FMT_LSB),
    .LAYOUT_BIT (LAYOUT_BIT),
    .WORD_BYTES (WORD_BYTES),
    .FMT_LO     (FMT_LO),
    .FMT_HI     (FMT_HI)
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .ctrl      (ctrl),
    .stackPtr  (stackPtr),
    .instrAddr (instrAddr),
    .memData   (memData),
    .memAddr   (memAddr),
    .frameOk   (frameOk),
    .statusOut (statusOut),
    .pcOut     (pcOut),
    .spOut     (spOut)
  );

endmodule

// File: rtl/exc_frame_pop_chk.sv
module exc_frame_pop_chk #(
  parameter int ADDR_W = 32,
  parameter int SR_W   = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              memReq,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memValid,
  input logic [SR_W-1:0]   statusOut,
  input logic [ADDR_W-1:0] spOut,
  input logic              donePulse,
  input logic              fmtErrPulse
);

  assert_flags_exclusive_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({donePulse, fmtErrPulse}));

  assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
    donePulse |=> !donePulse);

  assert_err_single_R5: assert property (@(posedge clk) disable iff (rst)
    fmtErrPulse |=> !fmtErrPulse);

  assert_err_keeps_state_R5: assert property (@(posedge clk) disable iff (rst)
    fmtErrPulse |-> ($stable(spOut) && $stable(statusOut)));

  assert_req_held_R2: assert property (@(posedge clk) disable iff (rst)
    (memReq && !memValid) |=> (memReq && $stable(memAddr)));

endmodule

bind exc_frame_pop exc_frame_pop_chk #(.ADDR_W(ADDR_W), .SR_W(SR_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .memReq      (memReq),
  .memAddr     (memAddr),
  .memValid    (memValid),
  .statusOut   (statusOut),
  .spOut       (spOut),
  .donePulse   (donePulse),
  .fmtErrPulse (fmtErrPulse)
);

// File: tb/exc_frame_pop_test.sv
module exc_frame_pop_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        startReq = 1'b0;
  logic [31:0] stackPtr = '0;
  logic [31:0] instrAddr = '0;
  logic        memReq;
  logic [31:0] memAddr;
  logic        memValid = 1'b0;
  logic [31:0] memData = '0;
  logic [15:0] statusOut;
  logic [31:0] pcOut;
  logic [31:0] spOut;
  logic        donePulse;
  logic        fmtErrPulse;
  logic        busy;

  int checkCount = 0;
  int failCount  = 0;

  logic [15:0] mStatus = '0;
  logic [31:0] mPc = '0;
  logic [31:0] mSp = '0;

  always #2 clk = ~clk;

  exc_frame_pop uut (
    .clk(clk), .rst(rst), .startReq(startReq), .stackPtr(stackPtr),
    .instrAddr(instrAddr), .memReq(memReq), .memAddr(memAddr),
    .memValid(memValid), .memData(memData), .statusOut(statusOut),
    .pcOut(pcOut), .spOut(spOut), .donePulse(donePulse),
    .fmtErrPulse(fmtErrPulse), .busy(busy)
  );

  typedef struct packed {
    logic [31:0] sp;
    logic [31:0] ia;
    logic [31:0] w1;
    logic [31:0] w2;
    logic [3:0]  lat;
    logic        expErr;
  } vec_t;

  localparam int NVEC = 10;
  localparam vec_t VECS [NVEC] = '{
    '{32'h0000_1000, 32'h0000_0400, 32'h4000_2700, 32'h0000_8000, 4'd0, 1'b0},
    '{32'h0000_1100, 32'h0000_0410, 32'h5000_ABCD, 32'h0001_2344, 4'd2, 1'b0},
    '{32'h0000_1200, 32'h0000_0420, 32'h6123_0011, 32'h00AB_CDE0, 4'd1, 1'b0},
    '{32'h0000_2000, 32'h0000_0430, 32'h7FFF_FFFF, 32'hDEAD_BEE0, 4'd3, 1'b0},
    '{32'hFFFF_FFF8, 32'h0000_0440, 32'h7000_0001, 32'h1234_5678, 4'd0, 1'b0},
    '{32'h0000_3000, 32'h0000_0500, 32'h0000_2700, 32'h1111_1111, 4'd1, 1'b1},
    '{32'h0000_3100, 32'h0000_0504, 32'h3000_1234, 32'h2222_2222, 4'd0, 1'b1},
    '{32'h0000_3200, 32'h0000_0508, 32'h8000_0001, 32'h3333_3333, 4'd2, 1'b1},
    '{32'h0000_3300, 32'h0000_050C, 32'hC000_5555, 32'h4444_4444, 4'd0, 1'b1},
    '{32'h0000_3400, 32'h0000_0510, 32'hF000_AAAA, 32'h5555_5555, 4'd1, 1'b1}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checkCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic chkEq(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    chk(act === exp, req, what, act, exp);
  endtask

  // one full sequence; poke drives extra start requests while busy
  task automatic runSeq(input vec_t v, input bit poke);
    logic [3:0]  fmt;
    bit          isErr;
    int          reads;
    fmt   = v.w1[31:28];
    isErr = !(fmt >= 4 && fmt <= 7);
    chk(isErr == v.expErr, "R3", "vector classification", 32'(isErr), 32'(v.expErr));
    @(negedge clk);
    startReq = 1'b1; stackPtr = v.sp; instrAddr = v.ia;
    @(negedge clk);
    startReq = 1'b0; stackPtr = 32'hAAAA_0000; instrAddr = 32'hBBBB_0000;
    reads = 0;
    for (int r = 0; r < 2; r++) begin
      chkEq("R2", "memReq raised", 32'(memReq), 32'd1);
      chkEq(r == 0 ? "R2" : "R7", "read address", memAddr, r == 0 ? v.sp : v.sp + 32'd4);
      for (int k = 0; k < int'(v.lat); k++) begin
        if (poke) begin
          startReq = 1'b1; stackPtr = 32'h0000_9000; instrAddr = 32'h0000_9900;
        end
        @(negedge clk);
        chkEq(poke ? "R10" : "R2", "address held while waiting", memAddr,
              r == 0 ? v.sp : v.sp + 32'd4);
        chkEq("R2", "memReq held while waiting", 32'(memReq), 32'd1);
      end
      startReq = 1'b0;
      memValid = 1'b1; memData = (r == 0) ? v.w1 : v.w2;
      @(negedge clk);
      memValid = 1'b0; memData = 32'hFFFF_FFFF;
      reads++;
      if (r == 0) begin
        if (isErr) begin
          mPc = v.ia;
          chkEq(v.w1[30] ? "R3" : "R4", "fmtErrPulse", 32'(fmtErrPulse), 32'd1);
          chkEq("R5", "no second read", 32'(memReq), 32'd0);
          chkEq("R5", "fault pc", pcOut, mPc);
          chkEq("R5", "status untouched", 32'(statusOut), 32'(mStatus));
          chkEq("R5", "sp untouched", spOut, mSp);
          chkEq("R9", "no done with error", 32'(donePulse), 32'd0);
          break;
        end else begin
          mStatus = v.w1[15:0];
          chkEq("R6", "status restored before second read", 32'(statusOut), 32'(mStatus));
          chkEq("R6", "second read pending", 32'(memReq), 32'd1);
          chkEq("R3", "no error on valid code", 32'(fmtErrPulse), 32'd0);
        end
      end else begin
        mPc = v.w2;
        mSp = v.sp + 32'd4 + 32'(fmt);
        chkEq("R8", "donePulse", 32'(donePulse), 32'd1);
        chkEq("R8", "new pc", pcOut, mPc);
        chkEq("R8", "new sp", spOut, mSp);
        chkEq("R9", "no error with done", 32'(fmtErrPulse), 32'd0);
      end
    end
    chkEq(isErr ? "R5" : "R8", "read count", 32'(reads), isErr ? 32'd1 : 32'd2);
    @(negedge clk);
    chkEq("R8", "done one cycle", 32'(donePulse), 32'd0);
    chkEq("R5", "error one cycle", 32'(fmtErrPulse), 32'd0);
    chkEq(poke ? "R10" : "R8", "idle after sequence", 32'(busy), 32'd0);
    chkEq(poke ? "R10" : "R8", "no request after sequence", 32'(memReq), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chkEq("R1", "statusOut reset", 32'(statusOut), 32'd0);
    chkEq("R1", "pcOut reset", pcOut, 32'd0);
    chkEq("R1", "spOut reset", spOut, 32'd0);
    chkEq("R1", "memReq reset", 32'(memReq), 32'd0);
    chkEq("R1", "busy reset", 32'(busy), 32'd0);
    chkEq("R1", "flags reset", 32'({donePulse, fmtErrPulse}), 32'd0);

    for (int i = 0; i < NVEC; i++) runSeq(VECS[i], 1'b0);

    // R10: start requests during a running sequence are ignored
    runSeq('{32'h0000_4000, 32'h0000_0600, 32'h4000_0042, 32'h0000_7770, 4'd4, 1'b0}, 1'b1);
    repeat (2) @(negedge clk);
    chkEq("R10", "no extra sequence", 32'(memReq), 32'd0);
    chkEq("R10", "results kept", spOut, 32'h0000_4008);

    // R1: reset in the middle of a sequence
    @(negedge clk);
    startReq = 1'b1; stackPtr = 32'h0000_5000;
    @(negedge clk);
    startReq = 1'b0;
    chkEq("R1", "busy before reset", 32'(busy), 32'd1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chkEq("R1", "memReq cleared mid-sequence", 32'(memReq), 32'd0);
    chkEq("R1", "busy cleared mid-sequence", 32'(busy), 32'd0);
    chkEq("R1", "spOut cleared", spOut, 32'd0);
    chkEq("R1", "pcOut cleared", pcOut, 32'd0);
    chkEq("R1", "statusOut cleared", 32'(statusOut), 32'd0);

    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checkCount++;
    failCount++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  end

endmodule